// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

This block takes a stream of per-page DMA addresses and builds a scatter-gather descriptor list in a memory buffer. A job begins with a start pulse. The pulse carries the base address of the list buffer, the byte offset of the transfer inside its first page, and the total transfer size in bytes. Two optional substitute addresses can also be given: one for a bounce-buffered head page and one for a bounce-buffered tail page. The block then takes exactly one page address per page over a valid/ready stream. It writes 16-byte descriptor entries through a one-entry-per-cycle write port and pulses `done` after the list has been terminated.

The list is laid out in blocks of eight 16-byte slots (128 bytes). A block that has another block after it opens with a chain entry that points to the next block, and carries seven data entries. Regions that are physically contiguous with the previous data entry are merged into that entry. The last block is compacted: its data entries start at slot 0 and are followed by an end-of-list entry.

A central state machine runs the job:
- IDLE goes to GATHER on an accepted start, or to ERR on a rejected one.
- GATHER takes pages. It goes to CHAIN when a new entry finds the block buffer full, and to DATA when the last page has been absorbed.
- CHAIN goes to DATA.
- DATA goes to END after the last entry of the final block. After a full non-final block it goes back to GATHER, or stays in DATA if the held-over entry came from the last page.
- END goes to DONE.
- DONE and ERR each return to IDLE.

Top module: `sgl_chain_builder`

## Requirements
- R1: After reset, `pg_ready`, `wr_en`, `done` and `err` are all low.
- R2: A start is rejected in either of two cases. The first is a transfer size of zero. The second is a required list size above `MAX_LIST_BYTES`, where the required size is 16 × (P + floor(P/7) + 1) and P = ceil((offset + size) / page size). A rejected start produces a one-cycle `err` pulse, no writes and no `done`.
- R3: For P pages, exactly P page handshakes are accepted. `pg_ready` is high only while the block is gathering, and stays low once the last page has been taken.
- R4: The first region starts at the given offset. Every region's length is the minimum of the remaining size and (page size − current offset). The offset is zero from the second page on.
- R5: With the head substitute enabled, the first region's address is the head substitute plus the offset. With the tail substitute enabled, the last page's region address is the tail substitute. If the transfer has a single page, the head rule wins.
- R6: A region whose start equals the end address of the previous data entry is added to that entry's length, and no new entry is created. Every data entry has flag value FLAG_DATA (default 0).
- R7: Each non-final block b has a chain entry in slot 0. Its target is base + 128·(b+1), its length is 128, and its flag is FLAG_CHAIN (default 1). Data entries fill slots 1 to 7.
- R8: The final block holds its n data entries in slots 0..n−1. Slot n holds an end entry with zero address, zero length and flag FLAG_END (default 2).
- R9: A block can become full and then have every later region merge into its last entry. That block is then the final one: no chain entry is written for it, and its end entry lands in slot 7.
- R10: Entry byte k sits at `wr_data[8k+7:8k]`. Bytes 0–7 hold the target address most significant byte first. Bytes 8–11 hold the length and bytes 12–15 the flag, each big-endian.
- R11: Write addresses rise by 16 from one write to the next. `done` is a one-cycle pulse in the cycle after the end entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a job (taken in IDLE only) |
| list_base | input | 64 | Base address of the list buffer |
| first_offs | input | PAGE_W | Byte offset into the first page |
| xfer_size | input | 32 | Total transfer size in bytes |
| head_bounce_en | input | 1 | Use the head substitute for the first page |
| head_bounce_addr | input | 64 | Head substitute page address |
| tail_bounce_en | input | 1 | Use the tail substitute for the last page |
| tail_bounce_addr | input | 64 | Tail substitute page address |
| pg_valid | input | 1 | Page address valid |
| pg_addr | input | 64 | Page DMA address |
| pg_ready | output | 1 | Page address accepted when high with `pg_valid` |
| wr_en | output | 1 | Descriptor write strobe |
| wr_addr | output | 64 | Descriptor byte address |
| wr_data | output | 128 | Descriptor entry, byte k in bits 8k+7:8k |
| done | output | 1 | One-cycle pulse when the list is terminated |
| err | output | 1 | One-cycle pulse on a rejected start |

## Verification
The stimulus patterns each separate one behaviour:
- Scattered pages with a nonzero first offset separate the head, middle and tail region lengths.
- Strictly contiguous pages must collapse into a single entry.
- A twenty-page scattered job, fed with gaps, produces two chain entries and a partially filled final block.
- Two jobs end with a page that is contiguous with the seventh entry of a block. They tell the shift-into-previous-block case apart from an ordinary final block.
- Head and tail substitutes are checked against both the offset arithmetic and the plain page addresses.
- Zero-size and oversize starts must produce an error and not a single write.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GATHER,
        S_CHAIN,
        S_DATA,
        S_END,
        S_DONE,
        S_ERR
    } sgl_state_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
    } sgl_ent_t;

    // Byte k of the entry goes to bits 8k+7:8k; each field is stored big-endian.
    function automatic logic [127:0] sgl_pack(input logic [63:0] tgt,
                                              input logic [31:0] len,
                                              input logic [31:0] flg);
        logic [127:0] w;
        w = '0;
        for (int k = 0; k < 8; k++) begin
            w[8*k +: 8] = tgt[8*(7-k) +: 8];
        end
        for (int k = 0; k < 4; k++) begin
            w[64 + 8*k +: 8] = len[8*(3-k) +: 8];
            w[96 + 8*k +: 8] = flg[8*(3-k) +: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/sgl_region_gen.sv
module sgl_region_gen #(
    parameter int PAGE_BYTES = 4096,
    parameter int CNT_W      = 32,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] ld_offs,
    input  logic [31:0]       ld_size,
    input  logic [CNT_W-1:0]  ld_pages,
    input  logic              ld_head_en,
    input  logic [63:0]       ld_head_addr,
    input  logic              ld_tail_en,
    input  logic [63:0]       ld_tail_addr,
    input  logic              step,
    input  logic [63:0]       pg_addr,
    output logic [63:0]       rg_addr,
    output logic [31:0]       rg_len,
    output logic              rg_last
);

    logic [PAGE_W-1:0] offs_q;
    logic [31:0]       remain_q;
    logic [CNT_W-1:0]  left_q;
    logic              first_q;
    logic              head_en_q;
    logic              tail_en_q;
    logic [63:0]       head_addr_q;
    logic [63:0]       tail_addr_q;

    logic [32:0]       room;
    logic [63:0]       offs64;

    assign offs64  = {{(64-PAGE_W){1'b0}}, offs_q};
    assign room    = 33'(PAGE_BYTES) - {{(33-PAGE_W){1'b0}}, offs_q};
    assign rg_len  = ({1'b0, remain_q} < room) ? remain_q : room[31:0];
    assign rg_last = (left_q == CNT_W'(1));

    always_comb begin
        if (first_q && head_en_q) begin
            rg_addr = head_addr_q + offs64;
        end else if (rg_last && tail_en_q) begin
            rg_addr = tail_addr_q;
        end else begin
            rg_addr = pg_addr + offs64;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offs_q      <= '0;
            remain_q    <= '0;
            left_q      <= '0;
            first_q     <= 1'b0;
            head_en_q   <= 1'b0;
            tail_en_q   <= 1'b0;
            head_addr_q <= '0;
            tail_addr_q <= '0;
        end else if (load) begin
            offs_q      <= ld_offs;
            remain_q    <= ld_size;
            left_q      <= ld_pages;
            first_q     <= 1'b1;
            head_en_q   <= ld_head_en;
            tail_en_q   <= ld_tail_en;
            head_addr_q <= ld_head_addr;
            tail_addr_q <= ld_tail_addr;
        end else if (step) begin
            offs_q   <= '0;
            remain_q <= remain_q - rg_len;
            left_q   <= left_q - CNT_W'(1);
            first_q  <= 1'b0;
        end
    end

    // R4: every accepted page contributes a non-empty region
    a_r4_region_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rg_len != 32'd0));

    // R3: the last page consumes exactly what remains of the transfer
    a_r3_last_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rg_last) |-> (rg_len == remain_q));

    // R3: no page is taken once the page count is exhausted
    a_r3_no_extra_page: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left_q != '0));

endmodule

// File: rtl/sgl_block_buf.sv
module sgl_block_buf
    import sgl_pkg::*;
#(
    parameter int DEPTH   = 7,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             merge,
    input  logic             restart,
    input  logic [63:0]      in_addr,
    input  logic [31:0]      in_len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_addr,
    output logic [31:0]      rd_len,
    output logic [CNT_W-1:0] cnt,
    output logic [63:0]      tail_end
);

    logic [CNT_W-1:0] cnt_q;
    logic [63:0]      tail_q;
    sgl_ent_t         ent_arr [DEPTH];
    sgl_ent_t         rd_ent;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sgl_ent_t ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if ((restart && (g == 0)) || (push && (cnt_q == CNT_W'(g)))) begin
                ent_q <= '{addr: in_addr, len: in_len};
            end else if (merge && (cnt_q == CNT_W'(g + 1))) begin
                ent_q.len <= ent_q.len + in_len;
            end
        end
        assign ent_arr[g] = ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tail_q <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
        end else if (restart) begin
            cnt_q  <= CNT_W'(1);
            tail_q <= in_addr + 64'(in_len);
        end else if (push) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            tail_q <= in_addr + 64'(in_len);
        end else if (merge) begin
            tail_q <= tail_q + 64'(in_len);
        end
    end

    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_ent = ent_arr[i];
        end
    end

    assign rd_addr  = rd_ent.addr;
    assign rd_len   = rd_ent.len;
    assign cnt      = cnt_q;
    assign tail_end = tail_q;

    // R9: the buffer never holds more than one block's data slots
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R9: a new entry is never appended to a full block
    a_r9_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CNT_W'(DEPTH)));

    // R6: merging always has a previous entry to extend
    a_r6_merge_has_tail: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (cnt_q != '0));

    // R6: at most one buffer operation per cycle
    a_r6_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear, push, merge, restart}));

endmodule

// File: rtl/sgl_chain_builder.sv
module sgl_chain_builder
    import sgl_pkg::*;
#(
    parameter int PAGE_BYTES     = 4096,
    parameter int SLOTS          = 8,
    parameter int MAX_LIST_BYTES = 65536,
    parameter int FLAG_DATA      = 0,
    parameter int FLAG_CHAIN     = 1,
    parameter int FLAG_END       = 2,
    localparam int PAGE_W        = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       list_base,
    input  logic [PAGE_W-1:0] first_offs,
    input  logic [31:0]       xfer_size,
    input  logic              head_bounce_en,
    input  logic [63:0]       head_bounce_addr,
    input  logic              tail_bounce_en,
    input  logic [63:0]       tail_bounce_addr,
    input  logic              pg_valid,
    input  logic [63:0]       pg_addr,
    output logic              pg_ready,
    output logic              wr_en,
    output logic [63:0]       wr_addr,
    output logic [127:0]      wr_data,
    output logic              done,
    output logic              err
);

    localparam int ENT_BYTES = 16;
    localparam int ENT_SH    = $clog2(ENT_BYTES);
    localparam int BLK_BYTES = SLOTS * ENT_BYTES;
    localparam int BLK_SH    = $clog2(BLK_BYTES);
    localparam int DEPTH     = SLOTS - 1;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int BCNT_W    = $clog2(DEPTH + 1);
    localparam int BIDX_W    = $clog2(DEPTH);
    localparam int PGCNT_W   = 32;

    sgl_state_e       state_q, state_d;

    logic [63:0]      base_q;
    logic [31:0]      blk_q;
    logic [SLOT_W-1:0] idx_q;
    logic             final_q;
    sgl_ent_t         pend_q;
    logic             pend_last_q;

    logic [63:0]      span, need_pages, need_bytes;
    logic             too_big;

    logic             rg_load, rg_step, rg_last;
    logic [63:0]      rg_addr;
    logic [31:0]      rg_len;

    logic             buf_clear, buf_push, buf_merge, buf_restart;
    logic [63:0]      buf_in_addr, buf_rd_addr, buf_tail;
    logic [31:0]      buf_in_len, buf_rd_len;
    logic [BCNT_W-1:0] buf_cnt;
    logic             buf_full, mergeable, data_last;

    logic [SLOT_W-1:0] slot;

    // ---------------- start screening ----------------
    always_comb begin
        span       = {32'd0, xfer_size} + 64'(first_offs);
        need_pages = (span + 64'(PAGE_BYTES - 1)) >> PAGE_W;
        need_bytes = (need_pages + need_pages / 64'(DEPTH) + 64'd1) << ENT_SH;
        too_big    = (xfer_size == 32'd0) || (need_bytes > 64'(MAX_LIST_BYTES));
    end

    // ---------------- region generator ----------------
    assign rg_load = (state_q == S_IDLE) && start && !too_big;
    assign rg_step = (state_q == S_GATHER) && pg_valid;

    sgl_region_gen #(
        .PAGE_BYTES (PAGE_BYTES),
        .CNT_W      (PGCNT_W)
    ) region_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (rg_load),
        .ld_offs      (first_offs),
        .ld_size      (xfer_size),
        .ld_pages     (need_pages[PGCNT_W-1:0]),
        .ld_head_en   (head_bounce_en),
        .ld_head_addr (head_bounce_addr),
        .ld_tail_en   (tail_bounce_en),
        .ld_tail_addr (tail_bounce_addr),
        .step         (rg_step),
        .pg_addr      (pg_addr),
        .rg_addr      (rg_addr),
        .rg_len       (rg_len),
        .rg_last      (rg_last)
    );

    // ---------------- block buffer ----------------
    assign mergeable   = (buf_cnt != '0) && (rg_addr == buf_tail);
    assign buf_full    = (buf_cnt == BCNT_W'(DEPTH));
    assign data_last   = (int'(idx_q) == int'(buf_cnt) - 1);

    assign buf_clear   = rg_load;
    assign buf_merge   = rg_step && mergeable;
    assign buf_push    = rg_step && !mergeable && !buf_full;
    assign buf_restart = (state_q == S_DATA) && !final_q && data_last;
    assign buf_in_addr = buf_restart ? pend_q.addr : rg_addr;
    assign buf_in_len  = buf_restart ? pend_q.len  : rg_len;

    sgl_block_buf #(
        .DEPTH (DEPTH)
    ) block_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .push     (buf_push),
        .merge    (buf_merge),
        .restart  (buf_restart),
        .in_addr  (buf_in_addr),
        .in_len   (buf_in_len),
        .rd_idx   (BIDX_W'(idx_q)),
        .rd_addr  (buf_rd_addr),
        .rd_len   (buf_rd_len),
        .cnt      (buf_cnt),
        .tail_end (buf_tail)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = too_big ? S_ERR : S_GATHER;
            end
            S_GATHER: begin
                if (pg_valid) begin
                    if (!mergeable && buf_full) state_d = S_CHAIN;
                    else if (rg_last)           state_d = S_DATA;
                end
            end
            S_CHAIN: state_d = S_DATA;
            S_DATA: begin
                if (data_last) begin
                    if (final_q)          state_d = S_END;
                    else if (pend_last_q) state_d = S_DATA;
                    else                  state_d = S_GATHER;
                end
            end
            S_END:  state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            S_ERR:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- job registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            blk_q       <= '0;
            idx_q       <= '0;
            final_q     <= 1'b0;
            pend_q      <= '0;
            pend_last_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (rg_load) begin
                        base_q  <= list_base;
                        blk_q   <= '0;
                        idx_q   <= '0;
                        final_q <= 1'b0;
                    end
                end
                S_GATHER: begin
                    if (pg_valid) begin
                        if (!mergeable && buf_full) begin
                            pend_q      <= '{addr: rg_addr, len: rg_len};
                            pend_last_q <= rg_last;
                            final_q     <= 1'b0;
                            idx_q       <= '0;
                        end else if (rg_last) begin
                            final_q <= 1'b1;
                            idx_q   <= '0;
                        end
                    end
                end
                S_DATA: begin
                    if (data_last) begin
                        idx_q <= '0;
                        if (!final_q) begin
                            blk_q   <= blk_q + 32'd1;
                            final_q <= pend_last_q;
                        end
                    end else begin
                        idx_q <= idx_q + SLOT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        pg_ready = 1'b0;
        wr_en    = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        slot     = '0;
        wr_data  = '0;
        unique case (state_q)
            S_GATHER: pg_ready = 1'b1;
            S_CHAIN: begin
                wr_en   = 1'b1;
                slot    = '0;
                wr_data = sgl_pack(base_q + ((64'(blk_q) + 64'd1) << BLK_SH),
                                   32'(BLK_BYTES), 32'(FLAG_CHAIN));
            end
            S_DATA: begin
                wr_en   = 1'b1;
                slot    = final_q ? idx_q : idx_q + SLOT_W'(1);
                wr_data = sgl_pack(buf_rd_addr, buf_rd_len, 32'(FLAG_DATA));
            end
            S_END: begin
                wr_en   = 1'b1;
                slot    = SLOT_W'(buf_cnt);
                wr_data = sgl_pack(64'd0, 32'd0, 32'(FLAG_END));
            end
            S_DONE: done = 1'b1;
            S_ERR:  err  = 1'b1;
            default: ;
        endcase
        wr_addr = base_q + (64'(blk_q) << BLK_SH) + (64'(slot) << ENT_SH);
    end

    // R11: consecutive writes walk the list buffer in 16-byte steps
    a_r11_seq_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 64'(ENT_BYTES)));

    // R2: no write falls outside the admitted list size
    a_r2_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_addr - base_q) < 64'(MAX_LIST_BYTES)));

    // R11: completion follows directly on the terminating write
    a_r11_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    // R3: pages are never taken while entries are being written
    a_r3_ready_not_writing: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> !pg_ready);

endmodule

// File: tb/sgl_chain_builder_tb_top.sv
module sgl_chain_builder_tb_top;

    localparam int PAGE  = 4096;
    localparam int PW    = 12;
    localparam int MAXB  = 65536;
    localparam int F_DAT = 0;
    localparam int F_CHN = 1;
    localparam int F_END = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   list_base = '0;
    logic [PW-1:0] first_offs = '0;
    logic [31:0]   xfer_size = '0;
    logic          head_bounce_en = 1'b0;
    logic [63:0]   head_bounce_addr = '0;
    logic          tail_bounce_en = 1'b0;
    logic [63:0]   tail_bounce_addr = '0;
    logic          pg_valid = 1'b0;
    logic [63:0]   pg_addr = '0;
    logic          pg_ready, wr_en, done, err;
    logic [63:0]   wr_addr;
    logic [127:0]  wr_data;

    always #5 clk = ~clk;

    sgl_chain_builder #(
        .PAGE_BYTES(PAGE), .SLOTS(8), .MAX_LIST_BYTES(MAXB),
        .FLAG_DATA(F_DAT), .FLAG_CHAIN(F_CHN), .FLAG_END(F_END)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
        .first_offs(first_offs), .xfer_size(xfer_size),
        .head_bounce_en(head_bounce_en), .head_bounce_addr(head_bounce_addr),
        .tail_bounce_en(tail_bounce_en), .tail_bounce_addr(tail_bounce_addr),
        .pg_valid(pg_valid), .pg_addr(pg_addr), .pg_ready(pg_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err)
    );

    typedef struct {
        logic [63:0]  a;
        logic [127:0] d;
        string        req;
    } exp_t;

    exp_t          expq[$];
    logic [63:0]   pgq[$];
    int            n_chk = 0;
    int            n_fail = 0;
    int            done_cnt = 0;
    int            err_cnt = 0;
    bit            finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Entry image per R10: byte k in bits 8k+7:8k, fields most significant byte first.
    function automatic logic [127:0] img(input logic [63:0] a, input logic [31:0] l,
                                         input int f);
        logic [7:0]   b [16];
        logic [127:0] w;
        logic [31:0]  fv;
        fv = 32'(f);
        for (int k = 0; k < 8; k++) b[k] = 8'(a >> (56 - 8*k));
        for (int k = 0; k < 4; k++) begin
            b[8 + k]  = 8'(l >> (24 - 8*k));
            b[12 + k] = 8'(fv >> (24 - 8*k));
        end
        for (int k = 0; k < 16; k++) w[8*k +: 8] = b[k];
        return w;
    endfunction

    task automatic expect_wr(input logic [63:0] a, input logic [127:0] d, input string req);
        exp_t e;
        e.a = a; e.d = d; e.req = req;
        expq.push_back(e);
    endtask

    // Scoreboard monitor: compares each write with the next expected entry.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (err)  err_cnt++;
            if (wr_en) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R11", "unexpected write", {64'd0, wr_addr}, 128'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(wr_addr == e.a, e.req, "entry address", {64'd0, wr_addr}, {64'd0, e.a});
                    chk(wr_data == e.d, e.req, "entry image", wr_data, e.d);
                end
            end
        end
    end

    // Builds the expected list from R4-R9 and pushes it to the scoreboard.
    task automatic model(input logic [63:0] base, input int offs, input int size,
                         input bit hv, input logic [63:0] ha,
                         input bit tv, input logic [63:0] ta, input string dreq,
                         input string ereq);
        logic [63:0] ea[$];
        logic [31:0] el[$];
        int          remain, off, len, np, nd, nfull, nlast;
        logic [63:0] a;
        remain = size; off = offs; np = pgq.size();
        for (int p = 0; p < np; p++) begin
            len = (remain < PAGE - off) ? remain : PAGE - off;
            if (p == 0 && hv)           a = ha + 64'(off);
            else if (p == np - 1 && tv) a = ta;
            else                        a = pgq[p] + 64'(off);
            if (ea.size() > 0 && a == ea[ea.size()-1] + 64'(el[el.size()-1]))
                el[el.size()-1] = el[el.size()-1] + 32'(len);
            else begin
                ea.push_back(a); el.push_back(32'(len));
            end
            remain -= len; off = 0;
        end
        nd = ea.size();
        nfull = (nd + 6) / 7 - 1;
        for (int b = 0; b < nfull; b++) begin
            expect_wr(base + 64'(b*128), img(base + 64'((b+1)*128), 32'd128, F_CHN), "R7");
            for (int k = 0; k < 7; k++)
                expect_wr(base + 64'(b*128 + 16*(k+1)), img(ea[b*7+k], el[b*7+k], F_DAT), dreq);
        end
        nlast = nd - 7*nfull;
        for (int k = 0; k < nlast; k++)
            expect_wr(base + 64'(nfull*128 + 16*k), img(ea[nfull*7+k], el[nfull*7+k], F_DAT), dreq);
        expect_wr(base + 64'(nfull*128 + 16*nlast), img(64'd0, 32'd0, F_END), ereq);
    endtask

    task automatic run_job(input string dreq, input string ereq, input logic [63:0] base,
                           input int offs, input int size,
                           input bit hv, input logic [63:0] ha,
                           input bit tv, input logic [63:0] ta,
                           input int gap, input bit bad);
        int d0, e0, extra, t;
        d0 = done_cnt; e0 = err_cnt; extra = 0;
        if (!bad) model(base, offs, size, hv, ha, tv, ta, dreq, ereq);
        @(negedge clk);
        start = 1'b1; list_base = base; first_offs = PW'(offs); xfer_size = 32'(size);
        head_bounce_en = hv; head_bounce_addr = ha;
        tail_bounce_en = tv; tail_bounce_addr = ta;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            repeat (4) begin
                #1 if (pg_ready) extra++;
                @(negedge clk);
            end
            chk(err_cnt == e0 + 1, "R2", "error pulse count", 128'(err_cnt - e0), 128'd1);
            chk(done_cnt == d0, "R2", "no done on reject", 128'(done_cnt - d0), 128'd0);
            chk(extra == 0, "R2", "no page taken on reject", 128'(extra), 128'd0);
            return;
        end
        for (int i = 0; i < pgq.size(); i++) begin
            pg_valid = 1'b1; pg_addr = pgq[i];
            forever begin
                #1;
                if (pg_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
            if (gap > 0) begin
                pg_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        pg_valid = 1'b1; pg_addr = 64'hDEAD_0000_0000_0000;
        repeat (12) begin
            #1 if (pg_ready) extra++;
            @(negedge clk);
        end
        pg_valid = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk); t++;
        end
        chk(done_cnt == d0 + 1, "R11", "done pulse", 128'(done_cnt - d0), 128'd1);
        chk(expq.size() == 0, "R11", "all entries written", 128'(expq.size()), 128'd0);
        chk(extra == 0, "R3", "no page beyond count", 128'(extra), 128'd0);
        chk(err_cnt == e0, "R2", "no error on valid job", 128'(err_cnt - e0), 128'd0);
        chk(!pg_ready, "R3", "ready low after job", 128'(pg_ready), 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 128'd0, 128'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!pg_ready, "R1", "pg_ready after reset", 128'(pg_ready), 128'd0);
        chk(!wr_en,    "R1", "wr_en after reset",    128'(wr_en),    128'd0);
        chk(!done,     "R1", "done after reset",     128'(done),     128'd0);
        chk(!err,      "R1", "err after reset",      128'(err),      128'd0);

        // R10: single page, known byte image
        pgq = {64'h0000_0001_2345_6000};
        run_job("R10", "R8", 64'h1000_0000, 32'h100, 32'h200, 0, 0, 0, 0, 0, 0);

        // R4: scattered pages, offset in first page
        pgq = {64'h10000, 64'h30000, 64'h50000, 64'h70000, 64'h90000};
        run_job("R4", "R8", 64'h2000_0000, 32'h800, 32'h4000, 0, 0, 0, 0, 1, 0);

        // R6: contiguous pages merge into one entry
        pgq = {64'h80000, 64'h81000, 64'h82000, 64'h83000};
        run_job("R6", "R8", 64'h2100_0000, 0, 32'h4000, 0, 0, 0, 0, 0, 0);

        // R7: twenty scattered pages, two chain entries
        pgq.delete();
        for (int i = 0; i < 20; i++) pgq.push_back(64'h100000 + 64'(i) * 64'h20000);
        run_job("R7", "R8", 64'h2200_0000, 32'h10, 19*PAGE, 0, 0, 0, 0, 2, 0);

        // R9: full block then merging page, single block
        pgq.delete();
        for (int i = 0; i < 7; i++) pgq.push_back(64'h400000 + 64'(i) * 64'h10000);
        pgq.push_back(64'h460000 + 64'h1000);
        run_job("R9", "R9", 64'h2300_0000, 0, 8*PAGE, 0, 0, 0, 0, 0, 0);

        // R9: second block becomes final after merge
        pgq.delete();
        for (int i = 0; i < 14; i++) pgq.push_back(64'h800000 + 64'(i) * 64'h10000);
        pgq.push_back(64'h800000 + 64'd13 * 64'h10000 + 64'h1000);
        run_job("R9", "R9", 64'h2400_0000, 0, 15*PAGE, 0, 0, 0, 0, 1, 0);

        // R5: head and tail substitutes
        pgq = {64'hA0000, 64'hC0000, 64'hE0000};
        run_job("R5", "R8", 64'h2500_0000, 32'h300, 32'h2000,
                1, 64'h7700_0000, 1, 64'h7800_0000, 0, 0);

        // R2: oversize and zero-size starts are rejected
        pgq.delete();
        run_job("R2", "R2", 64'h2600_0000, 0, 32'h0400_0000, 0, 0, 0, 0, 0, 1);
        run_job("R2", "R2", 64'h2600_0000, 32'h40, 0, 0, 0, 0, 0, 0, 1);

        // R8: normal job after rejections
        pgq = {64'h0000_0002_0000_0000, 64'h0000_0003_0000_0000};
        run_job("R8", "R8", 64'h2700_0000, 32'hF00, 32'h200, 0, 0, 0, 0, 0, 0);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule